// File: doc/BRIEF.md
# Low-power seconds counter with wake alarm

This block keeps wall-clock time in a free-running 47-bit counter clocked by a slow 32.768 kHz reference. The counter's upper 32 bits are whole seconds and its lower 15 bits are the fraction of a second. A 32-bit register port on the fast bus clock lets software do four things: start and stop counting, load the counter, program a one-shot seconds alarm, and observe and clear the alarm flag. When the alarm fires the block raises an interrupt and a wake request.

Control, load and clear requests cross from the bus domain into the slow domain through two-flop synchronisers. The counter value, the flag and the applied control bits return to the bus domain the same way. Every change therefore lands only after a few slow cycles. Software polls the control readback to learn when a change is in force. Because the two counter words are sampled at different times, software reads a word repeatedly until two successive reads agree.

Top module: `lp_rtc`

## Requirements
- R1: After reset every register reads zero, and irq_o and wake_o are low.
- R2: While counting is enabled the counter advances by one on each slow-clock rising edge. While counting is disabled it holds its value.
- R3: Offset 0x20 reads counter bits 31:0. Offset 0x1C reads counter bits 46:32 in bits 14:0, and its upper bits read zero. The seconds value is the counter shifted right by 15.
- R4: A write to 0x1C or 0x20 loads the counter only when counting is off, both as written and as read back. Otherwise the write is ignored.
- R5: Control register 0x04 has bit 0 for counting, bit 1 for the alarm and bit 3 for wake. A read returns the bits that are in force in the slow domain, so the read that follows a write still shows the old value. The new value appears a few slow cycles later.
- R6: The counter wraps from 2^47-1 to zero.
- R7: Status bit 0 at 0x18 becomes 1 when the alarm is enabled and the seconds value equals the 32-bit alarm register at 0x24. Once set, it stays set.
- R8: Writing 1 to status bit 0 clears the flag, and writing 0 has no effect. While the match condition still holds and the alarm is still enabled, the flag sets again.
- R9: irq_o is the flag ANDed with the applied alarm enable. wake_o is the flag ANDed with the applied wake enable.
- R10: With the alarm disabled, a matching seconds value does not set the flag.
- R11: Offset 0x30 stores a 32-bit value and returns it on read, for example the initialisation word 0x41736166.
- R12: Read data is registered and is valid in the cycle after the request. Unmapped offsets read zero. rdata_o holds its value when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| slow_clk_i | input | 1 | 32.768 kHz counting clock |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read request |
| irq_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | Alarm wake request |

## Verification
The assertions rely on four assumptions about the inputs:
- The slow clock is far slower than the bus clock, and its edges never coincide with bus edges.
- Software writes the counter words only after polling counting off.
- Software makes at most three counter-word writes in one slow period.
- Software changes the alarm register only while the alarm is disabled.

The bench keeps to these rules. It offsets the slow clock from the bus clock, polls the readback after every enable change, and loads the counter only when stopped. It places each alarm 64 slow cycles ahead, so a match is reached quickly without waiting out a whole second.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned CNT_W  = 47;
  localparam int unsigned FRAC_W = 15;
  localparam int unsigned SEC_W  = CNT_W - FRAC_W;
  localparam int unsigned HI_W   = CNT_W - 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_ALARM  = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_GUARD  = 8'h30;

  localparam int unsigned BIT_CNT  = 0;
  localparam int unsigned BIT_ALM  = 1;
  localparam int unsigned BIT_WAKE = 3;
  localparam int unsigned BIT_FLAG = 0;

  typedef struct packed {
    logic wake_en;
    logic alarm_en;
    logic cnt_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/lp_rtc_sync.sv
module lp_rtc_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [1:0]   age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end

  // cycles since reset, saturating; bounds the $past window below
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R5: every crossing shows its source two destination edges later
  a_r5_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/lp_rtc_core.sv
module lp_rtc_core
  import lp_rtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic [1:0]       ld_seq_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             clr_tgl_i,
  input  logic [SEC_W-1:0] alarm_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  logic [1:0] ld_seq_q;
  logic       clr_tgl_q;
  logic       ld, clr, hit;

  assign ld  = (ld_seq_i != ld_seq_q);
  assign clr = clr_tgl_i ^ clr_tgl_q;
  assign hit = ctrl_i.alarm_en && (cnt_o[CNT_W-1:FRAC_W] == alarm_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_seq_q  <= '0;
      clr_tgl_q <= 1'b0;
    end else begin
      ld_seq_q  <= ld_seq_i;
      clr_tgl_q <= clr_tgl_i;
    end
  end

  // ld_val_i is quasi-static: held by the bus side since before ld rose
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_o <= '0;
    else if (ld)             cnt_o <= ld_val_i;
    else if (ctrl_i.cnt_en)  cnt_o <= cnt_o + 1'b1;
  end

  // set has priority over clear while the match persists
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flag_o <= 1'b0;
    else if (hit)  flag_o <= 1'b1;
    else if (clr)  flag_o <= 1'b0;
  end

  a_r2_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.cnt_en && !ld) |=> $stable(cnt_o));

  a_r6_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.cnt_en && !ld && (&cnt_o)) |=> (cnt_o == '0));

  a_r7_flag_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.alarm_en && (cnt_o[CNT_W-1:FRAC_W] == alarm_i)) |=> flag_o);

  a_r10_flag_needs_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(ctrl_i.alarm_en));
endmodule

// File: rtl/lp_rtc_regs.sv
module lp_rtc_regs
  import lp_rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  ctrl_t             ctrl_rb_i,
  input  logic              flag_rb_i,
  input  logic [CNT_W-1:0]  cnt_rb_i,
  output ctrl_t             ctrl_o,
  output logic [1:0]        ld_seq_o,
  output logic [CNT_W-1:0]  ld_val_o,
  output logic              clr_tgl_o,
  output logic [SEC_W-1:0]  alarm_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [31:0] guard_q;
  logic [31:0] rd_word;
  logic        wr, rd, cnt_idle, cnt_wr;

  assign wr       = req_i && we_i;
  assign rd       = req_i && !we_i;
  assign cnt_idle = !ctrl_o.cnt_en && !ctrl_rb_i.cnt_en;
  assign cnt_wr   = wr && cnt_idle && (addr_i == OFF_CNT_HI || addr_i == OFF_CNT_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      alarm_o   <= '0;
      guard_q   <= '0;
      ld_val_o  <= '0;
      ld_seq_o  <= '0;
      clr_tgl_o <= 1'b0;
    end else begin
      if (wr) begin
        unique case (addr_i)
          OFF_CTRL:  ctrl_o <= '{wake_en:  wdata_i[BIT_WAKE],
                                 alarm_en: wdata_i[BIT_ALM],
                                 cnt_en:   wdata_i[BIT_CNT]};
          OFF_STAT:  if (wdata_i[BIT_FLAG]) clr_tgl_o <= ~clr_tgl_o;
          OFF_ALARM: alarm_o <= wdata_i[SEC_W-1:0];
          OFF_GUARD: guard_q <= wdata_i;
          OFF_CNT_HI: if (cnt_idle) ld_val_o[CNT_W-1:32] <= wdata_i[HI_W-1:0];
          OFF_CNT_LO: if (cnt_idle) ld_val_o[31:0] <= wdata_i;
          default: ;
        endcase
      end
      // gray step: several loads inside one slow period still differ from the last seen code
      if (cnt_wr) ld_seq_o <= {ld_seq_o[0], ~ld_seq_o[1]};
    end
  end

  always_comb begin
    rd_word = '0;
    unique case (addr_i)
      OFF_CTRL: begin
        rd_word[BIT_CNT]  = ctrl_rb_i.cnt_en;
        rd_word[BIT_ALM]  = ctrl_rb_i.alarm_en;
        rd_word[BIT_WAKE] = ctrl_rb_i.wake_en;
      end
      OFF_STAT:   rd_word[BIT_FLAG] = flag_rb_i;
      OFF_CNT_HI: rd_word[HI_W-1:0] = cnt_rb_i[CNT_W-1:32];
      OFF_CNT_LO: rd_word = cnt_rb_i[31:0];
      OFF_ALARM:  rd_word[SEC_W-1:0] = alarm_o;
      OFF_GUARD:  rd_word = guard_q;
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_word;
  end

  assign irq_o  = flag_rb_i & ctrl_rb_i.alarm_en;
  assign wake_o = flag_rb_i & ctrl_rb_i.wake_en;

  a_r4_load_blocked_when_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (addr_i == OFF_CNT_HI || addr_i == OFF_CNT_LO) && (ctrl_o.cnt_en || ctrl_rb_i.cnt_en))
      |=> ($stable(ld_seq_o) && $stable(ld_val_o)));

  a_r12_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));

  a_r8_clear_only_on_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && addr_i == OFF_STAT && wdata_i[BIT_FLAG]) |=> $stable(clr_tgl_o));
endmodule

// File: rtl/lp_rtc.sv
module lp_rtc
  import lp_rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_clk_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int unsigned FWD_W = CTRL_W + 2 + 1;
  localparam int unsigned BWD_W = CTRL_W + 1 + CNT_W;

  ctrl_t            ctrl_b, ctrl_s, ctrl_rb;
  logic [1:0]       ld_seq_b, ld_seq_s;
  logic             clr_tgl_b, clr_tgl_s;
  logic [CNT_W-1:0] ld_val_b, cnt_s, cnt_rb;
  logic [SEC_W-1:0] alarm_b;
  logic             flag_s, flag_rb;
  logic [FWD_W-1:0] fwd_q;
  logic [BWD_W-1:0] bwd_q;

  lp_rtc_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .ctrl_rb_i (ctrl_rb),
    .flag_rb_i (flag_rb),
    .cnt_rb_i  (cnt_rb),
    .ctrl_o    (ctrl_b),
    .ld_seq_o  (ld_seq_b),
    .ld_val_o  (ld_val_b),
    .clr_tgl_o (clr_tgl_b),
    .alarm_o   (alarm_b),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
  );

  lp_rtc_sync #(.W(FWD_W)) u_sync_fwd (
    .clk_i  (slow_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ctrl_b, ld_seq_b, clr_tgl_b}),
    .q_o    (fwd_q)
  );
  assign {ctrl_s, ld_seq_s, clr_tgl_s} = fwd_q;

  // alarm and load value are quasi-static: software changes them only while unused
  lp_rtc_core u_core (
    .clk_i     (slow_clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl_s),
    .ld_seq_i  (ld_seq_s),
    .ld_val_i  (ld_val_b),
    .clr_tgl_i (clr_tgl_s),
    .alarm_i   (alarm_b),
    .cnt_o     (cnt_s),
    .flag_o    (flag_s)
  );

  // counter words may tear; software re-reads until stable
  lp_rtc_sync #(.W(BWD_W)) u_sync_bwd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ctrl_s, flag_s, cnt_s}),
    .q_o    (bwd_q)
  );
  assign {ctrl_rb, flag_rb, cnt_rb} = bwd_q;
endmodule

// File: tb/lp_rtc_tb_top.sv
module lp_rtc_tb_top;
  logic        clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wake;
  int          n_chk = 0;
  int          n_fail = 0;

  localparam logic [7:0] A_CTRL = 8'h04, A_STAT = 8'h18, A_HI = 8'h1C,
                         A_LO = 8'h20, A_ALM = 8'h24, A_GRD = 8'h30;

  always #2 clk = ~clk;
  initial begin
    #1;
    forever #20 slow_clk = ~slow_clk;
  end

  lp_rtc dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .slow_clk_i (slow_clk),
    .req_i (req), .we_i (we), .addr_i (addr), .wdata_i (wdata),
    .rdata_o (rdata), .irq_o (irq), .wake_o (wake)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic read_stable(input logic [7:0] a, output logic [31:0] d);
    logic [31:0] v1, v2;
    bus_read(a, v1);
    for (int i = 0; i < 20; i++) begin
      bus_read(a, v2);
      if (v1 == v2) break;
      v1 = v2;
    end
    d = v2;
  endtask

  task automatic poll_cnt_en(input logic want, output int polls);
    logic [31:0] v;
    polls = 0;
    do begin
      bus_read(A_CTRL, v);
      polls++;
    end while (v[0] != want && polls < 100);
  endtask

  task automatic slow_wait(input int n);
    repeat (n) @(posedge slow_clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(irq == 1'b0, "R1 irq", {31'b0, irq}, 0);
    check(wake == 1'b0, "R1 wake", {31'b0, wake}, 0);
    bus_read(A_CTRL, v); check(v == 0, "R1 ctrl", v, 0);
    bus_read(A_STAT, v); check(v == 0, "R1 status", v, 0);
    bus_read(A_HI, v);   check(v == 0, "R1 cnt hi", v, 0);
    bus_read(A_LO, v);   check(v == 0, "R1 cnt lo", v, 0);
    bus_read(A_ALM, v);  check(v == 0, "R1 alarm", v, 0);
    bus_read(8'h08, v);  check(v == 0, "R12 unmapped", v, 0);
  endtask

  task automatic t_guard();
    logic [31:0] v;
    bus_write(A_GRD, 32'h4173_6166);
    bus_read(A_GRD, v); check(v == 32'h4173_6166, "R11 guard readback", v, 32'h4173_6166);
  endtask

  task automatic t_load();
    logic [31:0] v, w;
    bus_write(A_HI, 32'hFFFF_5A5A);
    bus_write(A_LO, (32'd5 << 15) | 32'h100);
    slow_wait(10);
    bus_read(A_HI, v); check(v == 32'h5A5A, "R3 hi field", v, 32'h5A5A);
    bus_read(A_LO, v); check(v == ((32'd5 << 15) | 32'h100), "R4 load when off", v, (32'd5 << 15) | 32'h100);
    slow_wait(20);
    bus_read(A_LO, w); check(w == v, "R2 hold when off", w, v);
    bus_write(A_HI, 32'h0);
    slow_wait(10);
  endtask

  task automatic t_enable();
    logic [31:0] v, a, b;
    int polls;
    bus_write(A_CTRL, 32'h1);
    bus_read(A_CTRL, v); check(v[0] == 1'b0, "R5 readback lags", v, 0);
    poll_cnt_en(1'b1, polls);
    check(polls > 1 && polls < 40, "R5 readback settles", polls, 1);
    read_stable(A_LO, a);
    check((a >> 15) == 5, "R3 seconds field", a >> 15, 5);
    repeat (200) @(negedge clk);
    read_stable(A_LO, b);
    check((b - a) >= 19 && (b - a) <= 21, "R2 one step per slow edge", b - a, 20);
    bus_write(A_LO, 32'h0);
    bus_write(A_HI, 32'h7FFF);
    slow_wait(10);
    read_stable(A_LO, v); check(v > b, "R4 lo write ignored while running", v, b);
    bus_read(A_HI, v); check(v == 0, "R4 hi write ignored while running", v, 0);
  endtask

  task automatic t_disable();
    logic [31:0] d, e;
    int polls;
    bus_write(A_CTRL, 32'h0);
    poll_cnt_en(1'b0, polls);
    check(polls < 40, "R5 disable settles", polls, 1);
    read_stable(A_LO, d);
    slow_wait(20);
    bus_read(A_LO, e); check(e == d, "R2 frozen after disable", e, d);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    int polls;
    bus_write(A_HI, 32'h7FFF);
    bus_write(A_LO, 32'hFFFF_FFE0);
    slow_wait(10);
    bus_read(A_HI, v); check(v == 32'h7FFF, "R3 hi top value", v, 32'h7FFF);
    bus_write(A_CTRL, 32'h1);
    poll_cnt_en(1'b1, polls);
    slow_wait(100);
    bus_write(A_CTRL, 32'h0);
    poll_cnt_en(1'b0, polls);
    bus_read(A_HI, v); check(v == 0, "R6 hi wrapped", v, 0);
    bus_read(A_LO, v); check(v > 32 && v < 200, "R6 lo after wrap", v, 100);
  endtask

  task automatic load_secs(input logic [31:0] secs, input logic [31:0] alm);
    bus_write(A_HI, 32'h0);
    bus_write(A_LO, (secs << 15) | 32'h7FC0);
    bus_write(A_ALM, alm);
    slow_wait(10);
  endtask

  task automatic t_alarm_off();
    logic [31:0] v;
    int polls;
    load_secs(29, 30);
    bus_write(A_CTRL, 32'h1);
    poll_cnt_en(1'b1, polls);
    slow_wait(150);
    read_stable(A_LO, v); check((v >> 15) == 30, "R10 match reached", v >> 15, 30);
    bus_read(A_STAT, v); check(v == 0, "R10 no flag when alarm off", v, 0);
    check(irq == 1'b0, "R10 irq low", {31'b0, irq}, 0);
    bus_write(A_CTRL, 32'h0);
    poll_cnt_en(1'b0, polls);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    int polls;
    load_secs(9, 10);
    bus_write(A_CTRL, 32'hB);
    poll_cnt_en(1'b1, polls);
    bus_read(A_CTRL, v); check(v == 32'hB, "R5 ctrl bits readback", v, 32'hB);
    bus_read(A_STAT, v); check(v == 0, "R7 no flag before match", v, 0);
    slow_wait(150);
    bus_read(A_STAT, v); check(v == 1, "R7 flag on match", v, 1);
    check(irq == 1'b1, "R9 irq with alarm on", {31'b0, irq}, 1);
    check(wake == 1'b1, "R9 wake with wake on", {31'b0, wake}, 1);
    bus_write(A_CTRL, 32'h1);
    slow_wait(10);
    check(irq == 1'b0, "R9 irq gated by alarm enable", {31'b0, irq}, 0);
    check(wake == 1'b0, "R9 wake gated by wake enable", {31'b0, wake}, 0);
    bus_read(A_STAT, v); check(v == 1, "R7 flag sticky", v, 1);
    bus_write(A_STAT, 32'h0);
    slow_wait(10);
    bus_read(A_STAT, v); check(v == 1, "R8 write zero ignored", v, 1);
    bus_write(A_STAT, 32'h1);
    slow_wait(10);
    bus_read(A_STAT, v); check(v == 0, "R8 write one clears", v, 0);
  endtask

  task automatic t_wake_gate();
    logic [31:0] v;
    int polls;
    bus_write(A_CTRL, 32'h0);
    poll_cnt_en(1'b0, polls);
    load_secs(19, 20);
    bus_write(A_CTRL, 32'h3);
    poll_cnt_en(1'b1, polls);
    slow_wait(150);
    bus_read(A_STAT, v); check(v == 1, "R7 flag second match", v, 1);
    check(irq == 1'b1, "R9 irq set", {31'b0, irq}, 1);
    check(wake == 1'b0, "R9 wake off without wake enable", {31'b0, wake}, 0);
    bus_write(A_STAT, 32'h1);
    slow_wait(10);
    bus_read(A_STAT, v); check(v == 1, "R8 set wins while match holds", v, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_guard();
    t_load();
    t_enable();
    t_disable();
    t_wrap();
    t_alarm_off();
    t_alarm();
    t_wake_gate();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd150000, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule